// File: doc/BRIEF.md
# Serial Port Transmit/Receive Byte FIFOs

This block holds the two data queues of a serial port controller. On one side it faces a register-style access port, used by the CPU or by a DMA engine. A write to the transmit data register pushes 1, 2 or 4 bytes into the transmit queue. A read of the receive data register pops 1, 2 or 4 bytes from the receive queue. On the other side it faces the serial shifter, which takes one byte at a time from the transmit queue and delivers one byte at a time into the receive queue.

Occupancy is counted in bytes. Each queue compares its fill level with a programmable trigger, which software sets in steps of `TRIG_STEP` bytes. The result drives an interrupt request. When DMA is enabled for a direction, that direction drives a DMA request line. The transmit rule asks for data while room remains, and the receive rule asks for service while data is waiting. The shallow build (64 bytes, 1-byte steps) and the deep build (256 bytes, 4-byte steps) come from the same source through parameters.

Top module: `spi_xfer_fifos`

## Requirements
- R1: After reset both levels read 0, all four error flags are low, `rx_dma_req_o` is low, `tx_dma_req_o` equals `tx_dma_en_i`, and `tx_irq_o` is high.
- R2: `width_i` sets the access size: 2'b00 moves 1 byte, 2'b01 moves 2 bytes, and 2'b10 or 2'b11 moves 4 bytes. `tx_level_o` and `rx_level_o` count stored bytes and never exceed `DEPTH`.
- R3: An accepted write stores the low 1, 2 or 4 bytes of `tx_wdata_i`, bits 7:0 first. The shifter receives transmit bytes on `sh_tx_byte_o` in the order they were stored, and an accepted `sh_tx_pop_i` removes one byte.
- R4: During a read, `rx_rdata_o` carries the oldest received byte in bits 7:0 and the next ones in bits 15:8, 23:16 and 31:24 as the width allows. Bits above the access width read 0.
- R5: A write that needs more bytes than are free is dropped whole and sets the sticky `tx_ovr_o`. A shifter push into a full receive queue is dropped and sets the sticky `rx_ovr_o`.
- R6: A read with fewer bytes stored than the access width is dropped and sets the sticky `rx_udr_o`. A shifter pop from an empty transmit queue is dropped and sets the sticky `tx_udr_o`. `sh_tx_avail_o` is high exactly while the transmit queue holds a byte.
- R7: The threshold is trigger times `TRIG_STEP` bytes. `rx_irq_o` is high while the receive level is at or above its threshold. `tx_irq_o` is high while the transmit level is at or below its threshold.
- R8: `tx_dma_req_o` is high exactly when `tx_dma_en_i` is set and the free space is at least one access width.
- R9: `rx_dma_req_o` is high exactly when `rx_dma_en_i` is set and the receive level is at least one access width.
- R10: When a push and a pop reach the same queue in one cycle, both are judged against the level before the edge, and the level changes by their difference.
- R11: Error flags stay set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| width_i | input | 2 | Access size select |
| tx_wr_i | input | 1 | Transmit data register write |
| tx_wdata_i | input | 32 | Transmit write data |
| rx_rd_i | input | 1 | Receive data register read |
| rx_rdata_o | output | 32 | Receive read data, valid while reading |
| sh_tx_pop_i | input | 1 | Shifter takes one transmit byte |
| sh_tx_byte_o | output | 8 | Oldest transmit byte |
| sh_tx_avail_o | output | 1 | Transmit queue not empty |
| sh_rx_push_i | input | 1 | Shifter delivers one receive byte |
| sh_rx_byte_i | input | 8 | Received byte |
| tx_trig_i | input | TRIG_W | Transmit trigger, in steps |
| rx_trig_i | input | TRIG_W | Receive trigger, in steps |
| tx_dma_en_i | input | 1 | Transmit DMA enable |
| rx_dma_en_i | input | 1 | Receive DMA enable |
| tx_level_o | output | LVL_W | Transmit bytes stored |
| rx_level_o | output | LVL_W | Receive bytes stored |
| tx_irq_o | output | 1 | Transmit threshold interrupt |
| rx_irq_o | output | 1 | Receive threshold interrupt |
| tx_dma_req_o | output | 1 | Transmit DMA request |
| rx_dma_req_o | output | 1 | Receive DMA request |
| tx_ovr_o | output | 1 | Sticky transmit overflow |
| tx_udr_o | output | 1 | Sticky transmit underflow |
| rx_ovr_o | output | 1 | Sticky receive overflow |
| rx_udr_o | output | 1 | Sticky receive underflow |

## Verification
The assertions assume that `width_i` holds steady during any cycle in which the bus writes or reads. Their level arithmetic takes the access size from the same cycle as the request. The stimulus changes the width, the triggers and the DMA enables only on cycles with no bus access, and it always drives every strobe to a known value. Inside those limits it mixes random traffic with overflow and underflow attempts on both sides, and with same-cycle push/pop pairs.

// File: rtl/spi_fifo_pkg.sv
`timescale 1ns/1ps
package spi_fifo_pkg;
  typedef enum logic [1:0] {
    ACC_B8  = 2'b00,
    ACC_B16 = 2'b01,
    ACC_B32 = 2'b10,
    ACC_B32X = 2'b11
  } acc_width_e;

  localparam int BUS_LANES = 4;

  function automatic logic [2:0] acc_bytes(input logic [1:0] w);
    case (acc_width_e'(w))
      ACC_B8:  return 3'd1;
      ACC_B16: return 3'd2;
      default: return 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/spi_byte_fifo.sv
`timescale 1ns/1ps
module spi_byte_fifo #(
  parameter int DEPTH    = 64,
  parameter int WR_LANES = 4,
  parameter int RD_LANES = 1,
  localparam int PTR_W  = $clog2(DEPTH),
  localparam int LVL_W  = PTR_W + 1,
  localparam int WCNT_W = $clog2(WR_LANES) + 1,
  localparam int RCNT_W = $clog2(RD_LANES) + 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_req_i,
  input  logic [WCNT_W-1:0]     wr_cnt_i,
  input  logic [8*WR_LANES-1:0] wr_data_i,
  input  logic                  rd_req_i,
  input  logic [RCNT_W-1:0]     rd_cnt_i,
  output logic [8*RD_LANES-1:0] rd_data_o,
  output logic [LVL_W-1:0]      level_o,
  output logic                  ovr_o,
  output logic                  udr_o
);
  logic [7:0]       mem_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [LVL_W-1:0] level_q, free_w, add_n, sub_n;
  logic             wr_ok, rd_ok;

  // both sides judged on the pre-edge level
  assign free_w = LVL_W'(DEPTH) - level_q;
  assign wr_ok  = wr_req_i && (free_w >= LVL_W'(wr_cnt_i));
  assign rd_ok  = rd_req_i && (level_q >= LVL_W'(rd_cnt_i));
  assign add_n  = wr_ok ? LVL_W'(wr_cnt_i) : '0;
  assign sub_n  = rd_ok ? LVL_W'(rd_cnt_i) : '0;

  always_ff @(posedge clk_i) begin
    if (wr_ok) begin
      for (int k = 0; k < WR_LANES; k++) begin
        if (WCNT_W'(k) < wr_cnt_i) mem_q[wr_ptr_q + PTR_W'(k)] <= wr_data_i[8*k +: 8];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      level_q  <= '0;
      ovr_o    <= 1'b0;
      udr_o    <= 1'b0;
    end else begin
      if (wr_ok) wr_ptr_q <= wr_ptr_q + PTR_W'(wr_cnt_i);
      if (rd_ok) rd_ptr_q <= rd_ptr_q + PTR_W'(rd_cnt_i);
      level_q <= level_q + add_n - sub_n;
      if (wr_req_i && !wr_ok) ovr_o <= 1'b1;
      if (rd_req_i && !rd_ok) udr_o <= 1'b1;
    end
  end

  for (genvar k = 0; k < RD_LANES; k++) begin : g_rd
    assign rd_data_o[8*k +: 8] = mem_q[rd_ptr_q + PTR_W'(k)];
  end

  assign level_o = level_q;
endmodule

// File: rtl/spi_fifo_watch.sv
`timescale 1ns/1ps
module spi_fifo_watch #(
  parameter int DEPTH     = 64,
  parameter int TRIG_W    = 6,
  parameter int TRIG_STEP = 1,
  parameter bit IS_TX     = 1'b1,
  localparam int LVL_W  = $clog2(DEPTH) + 1,
  localparam int STEP_W = $clog2(TRIG_STEP) + 1,
  localparam int CW     = ((LVL_W > TRIG_W + STEP_W) ? LVL_W : TRIG_W + STEP_W) + 1
) (
  input  logic [LVL_W-1:0]  level_i,
  input  logic [TRIG_W-1:0] trig_i,
  input  logic              dma_en_i,
  input  logic [2:0]        acc_cnt_i,
  output logic              irq_o,
  output logic              dma_req_o
);
  logic [CW-1:0] thr, lvl, room, cnt;

  assign thr  = CW'(trig_i) * CW'(TRIG_STEP);
  assign lvl  = CW'(level_i);
  assign room = CW'(DEPTH) - lvl;
  assign cnt  = CW'(acc_cnt_i);

  if (IS_TX) begin : g_tx
    assign irq_o     = lvl <= thr;
    assign dma_req_o = dma_en_i && (room >= cnt);
  end else begin : g_rx
    assign irq_o     = lvl >= thr;
    assign dma_req_o = dma_en_i && (lvl >= cnt);
  end
endmodule

// File: rtl/spi_xfer_fifos.sv
`timescale 1ns/1ps
module spi_xfer_fifos
  import spi_fifo_pkg::*;
#(
  parameter int DEPTH     = 64,
  parameter int TRIG_W    = 6,
  parameter int TRIG_STEP = 1,
  localparam int LVL_W = $clog2(DEPTH) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        width_i,
  input  logic              tx_wr_i,
  input  logic [31:0]       tx_wdata_i,
  input  logic              rx_rd_i,
  output logic [31:0]       rx_rdata_o,
  input  logic              sh_tx_pop_i,
  output logic [7:0]        sh_tx_byte_o,
  output logic              sh_tx_avail_o,
  input  logic              sh_rx_push_i,
  input  logic [7:0]        sh_rx_byte_i,
  input  logic [TRIG_W-1:0] tx_trig_i,
  input  logic [TRIG_W-1:0] rx_trig_i,
  input  logic              tx_dma_en_i,
  input  logic              rx_dma_en_i,
  output logic [LVL_W-1:0]  tx_level_o,
  output logic [LVL_W-1:0]  rx_level_o,
  output logic              tx_irq_o,
  output logic              rx_irq_o,
  output logic              tx_dma_req_o,
  output logic              rx_dma_req_o,
  output logic              tx_ovr_o,
  output logic              tx_udr_o,
  output logic              rx_ovr_o,
  output logic              rx_udr_o
);
  localparam int LANE_CW = $clog2(BUS_LANES) + 1;

  logic [2:0]             nb;
  logic [8*BUS_LANES-1:0] rx_raw;

  assign nb = acc_bytes(width_i);

  spi_byte_fifo #(.DEPTH(DEPTH), .WR_LANES(BUS_LANES), .RD_LANES(1)) u_tx_q (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_req_i  (tx_wr_i),
    .wr_cnt_i  (LANE_CW'(nb)),
    .wr_data_i (tx_wdata_i),
    .rd_req_i  (sh_tx_pop_i),
    .rd_cnt_i  (1'b1),
    .rd_data_o (sh_tx_byte_o),
    .level_o   (tx_level_o),
    .ovr_o     (tx_ovr_o),
    .udr_o     (tx_udr_o)
  );

  spi_byte_fifo #(.DEPTH(DEPTH), .WR_LANES(1), .RD_LANES(BUS_LANES)) u_rx_q (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_req_i  (sh_rx_push_i),
    .wr_cnt_i  (1'b1),
    .wr_data_i (sh_rx_byte_i),
    .rd_req_i  (rx_rd_i),
    .rd_cnt_i  (LANE_CW'(nb)),
    .rd_data_o (rx_raw),
    .level_o   (rx_level_o),
    .ovr_o     (rx_ovr_o),
    .udr_o     (rx_udr_o)
  );

  // lanes beyond the access width read zero
  for (genvar k = 0; k < BUS_LANES; k++) begin : g_lane
    assign rx_rdata_o[8*k +: 8] = (3'(k) < nb) ? rx_raw[8*k +: 8] : 8'h00;
  end

  assign sh_tx_avail_o = tx_level_o != '0;

  spi_fifo_watch #(.DEPTH(DEPTH), .TRIG_W(TRIG_W), .TRIG_STEP(TRIG_STEP), .IS_TX(1'b1)) u_tx_watch (
    .level_i   (tx_level_o),
    .trig_i    (tx_trig_i),
    .dma_en_i  (tx_dma_en_i),
    .acc_cnt_i (nb),
    .irq_o     (tx_irq_o),
    .dma_req_o (tx_dma_req_o)
  );

  spi_fifo_watch #(.DEPTH(DEPTH), .TRIG_W(TRIG_W), .TRIG_STEP(TRIG_STEP), .IS_TX(1'b0)) u_rx_watch (
    .level_i   (rx_level_o),
    .trig_i    (rx_trig_i),
    .dma_en_i  (rx_dma_en_i),
    .acc_cnt_i (nb),
    .irq_o     (rx_irq_o),
    .dma_req_o (rx_dma_req_o)
  );
endmodule

// File: rtl/spi_xfer_fifos_chk.sv
`timescale 1ns/1ps
module spi_xfer_fifos_chk
  import spi_fifo_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int LVL_W = $clog2(DEPTH) + 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [1:0]       width_i,
  input logic             tx_wr_i,
  input logic             rx_rd_i,
  input logic             sh_tx_pop_i,
  input logic             sh_rx_push_i,
  input logic             tx_dma_en_i,
  input logic             rx_dma_en_i,
  input logic [LVL_W-1:0] tx_level_o,
  input logic [LVL_W-1:0] rx_level_o,
  input logic             tx_dma_req_o,
  input logic             rx_dma_req_o,
  input logic             tx_ovr_o,
  input logic             tx_udr_o,
  input logic             rx_ovr_o,
  input logic             rx_udr_o
);
  logic [LVL_W-1:0] nb_l, tx_free;
  assign nb_l    = LVL_W'(acc_bytes(width_i));
  assign tx_free = LVL_W'(DEPTH) - tx_level_o;

  a_r2_level_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_level_o <= LVL_W'(DEPTH)) && (rx_level_o <= LVL_W'(DEPTH)));

  a_r3_push_adds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_wr_i && !sh_tx_pop_i && tx_free >= nb_l) |=> tx_level_o == $past(tx_level_o) + $past(nb_l));

  a_r5_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_wr_i && !sh_tx_pop_i && tx_free < nb_l) |=> ($stable(tx_level_o) && tx_ovr_o));

  a_r6_no_underrun: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_rd_i && !sh_rx_push_i && rx_level_o < nb_l) |=> ($stable(rx_level_o) && rx_udr_o));

  a_r8_tx_dma_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_dma_req_o |-> (tx_dma_en_i && tx_level_o != LVL_W'(DEPTH)));

  a_r9_rx_dma_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_dma_req_o |-> (rx_dma_en_i && rx_level_o != '0));

  a_r11_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_ovr_o || tx_udr_o || rx_ovr_o || rx_udr_o) |=>
      ((tx_ovr_o || !$past(tx_ovr_o)) && (tx_udr_o || !$past(tx_udr_o)) &&
       (rx_ovr_o || !$past(rx_ovr_o)) && (rx_udr_o || !$past(rx_udr_o))));
endmodule

bind spi_xfer_fifos spi_xfer_fifos_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .width_i      (width_i),
  .tx_wr_i      (tx_wr_i),
  .rx_rd_i      (rx_rd_i),
  .sh_tx_pop_i  (sh_tx_pop_i),
  .sh_rx_push_i (sh_rx_push_i),
  .tx_dma_en_i  (tx_dma_en_i),
  .rx_dma_en_i  (rx_dma_en_i),
  .tx_level_o   (tx_level_o),
  .rx_level_o   (rx_level_o),
  .tx_dma_req_o (tx_dma_req_o),
  .rx_dma_req_o (rx_dma_req_o),
  .tx_ovr_o     (tx_ovr_o),
  .tx_udr_o     (tx_udr_o),
  .rx_ovr_o     (rx_ovr_o),
  .rx_udr_o     (rx_udr_o)
);

// File: tb/spi_xfer_fifos_tb.sv
`timescale 1ns/1ps
module spi_xfer_fifos_tb;
  localparam int DEPTH = 64;
  localparam int TRIG_W = 6;
  localparam int TRIG_STEP = 1;
  localparam int LVL_W = $clog2(DEPTH) + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] width = 2'b00;
  logic tx_wr = 0, rx_rd = 0, sh_pop = 0, sh_push = 0;
  logic [31:0] tx_wdata = '0;
  logic [7:0] sh_byte = '0;
  logic [TRIG_W-1:0] tx_trig = '0, rx_trig = '0;
  logic tx_den = 0, rx_den = 0;
  logic [31:0] rx_rdata;
  logic [7:0] sh_tx_byte;
  logic sh_tx_avail;
  logic [LVL_W-1:0] tx_level, rx_level;
  logic tx_irq, rx_irq, tx_dreq, rx_dreq, tx_ovr, tx_udr, rx_ovr, rx_udr;

  always #2.5 clk = ~clk;

  spi_xfer_fifos #(.DEPTH(DEPTH), .TRIG_W(TRIG_W), .TRIG_STEP(TRIG_STEP)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .width_i(width),
    .tx_wr_i(tx_wr), .tx_wdata_i(tx_wdata), .rx_rd_i(rx_rd), .rx_rdata_o(rx_rdata),
    .sh_tx_pop_i(sh_pop), .sh_tx_byte_o(sh_tx_byte), .sh_tx_avail_o(sh_tx_avail),
    .sh_rx_push_i(sh_push), .sh_rx_byte_i(sh_byte),
    .tx_trig_i(tx_trig), .rx_trig_i(rx_trig), .tx_dma_en_i(tx_den), .rx_dma_en_i(rx_den),
    .tx_level_o(tx_level), .rx_level_o(rx_level), .tx_irq_o(tx_irq), .rx_irq_o(rx_irq),
    .tx_dma_req_o(tx_dreq), .rx_dma_req_o(rx_dreq),
    .tx_ovr_o(tx_ovr), .tx_udr_o(tx_udr), .rx_ovr_o(rx_ovr), .rx_udr_o(rx_udr)
  );

  logic [7:0] tq[$];
  logic [7:0] rq[$];
  bit e_tovr, e_tudr, e_rovr, e_rudr;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  function automatic int nbytes(logic [1:0] w);
    return (w == 2'b00) ? 1 : (w == 2'b01) ? 2 : 4;
  endfunction

  function automatic logic [31:0] rx_expect(int n);
    logic [31:0] v = '0;
    for (int k = 0; k < n; k++) v[8*k +: 8] = rq[k];
    return v;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_state();
    int nb = nbytes(width);
    int tthr = int'(tx_trig) * TRIG_STEP;
    int rthr = int'(rx_trig) * TRIG_STEP;
    chk("R2 tx level", 32'(tx_level), 32'(tq.size()));
    chk("R2 rx level", 32'(rx_level), 32'(rq.size()));
    chk("R6 tx avail", 32'(sh_tx_avail), 32'(tq.size() != 0));
    chk("R7 tx irq", 32'(tx_irq), 32'(tq.size() <= tthr));
    chk("R7 rx irq", 32'(rx_irq), 32'(rq.size() >= rthr));
    chk("R8 tx dma", 32'(tx_dreq), 32'(tx_den && (DEPTH - tq.size()) >= nb));
    chk("R9 rx dma", 32'(rx_dreq), 32'(rx_den && rq.size() >= nb));
    chk("R11 flags", {28'b0, tx_ovr, tx_udr, rx_ovr, rx_udr}, {28'b0, e_tovr, e_tudr, e_rovr, e_rudr});
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    tx_wr = 0; rx_rd = 0; sh_pop = 0; sh_push = 0;
    repeat (3) @(negedge clk);
    tq.delete(); rq.delete();
    e_tovr = 0; e_tudr = 0; e_rovr = 0; e_rudr = 0;
    rst_n = 1;
    #1;
  endtask

  // one cycle of traffic; inputs set at negedge, results checked after the edge
  task automatic step(bit wr, logic [31:0] wd, bit rd, bit pop, bit push, logic [7:0] pb);
    int nb;
    bit ok_w, ok_r, ok_pop, ok_push;
    @(negedge clk);
    tx_wr = wr; tx_wdata = wd; rx_rd = rd; sh_pop = pop; sh_push = push; sh_byte = pb;
    #1;
    nb = nbytes(width);
    ok_w = wr && (DEPTH - tq.size()) >= nb;
    ok_r = rd && rq.size() >= nb;
    ok_pop = pop && tq.size() >= 1;
    ok_push = push && rq.size() < DEPTH;
    if (ok_pop) chk("R3 tx byte order", 32'(sh_tx_byte), 32'(tq[0]));
    if (ok_r) chk("R4 read assembly", rx_rdata, rx_expect(nb));
    @(posedge clk);
    #1;
    tx_wr = 0; rx_rd = 0; sh_pop = 0; sh_push = 0;
    if (ok_pop) void'(tq.pop_front());
    if (ok_w) for (int k = 0; k < nb; k++) tq.push_back(wd[8*k +: 8]);
    if (ok_r) for (int k = 0; k < nb; k++) void'(rq.pop_front());
    if (ok_push) rq.push_back(pb);
    if (wr && !ok_w) e_tovr = 1;
    if (pop && !ok_pop) e_tudr = 1;
    if (push && !ok_push) e_rovr = 1;
    if (rd && !ok_r) e_rudr = 1;
    check_state();
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int seed_v;
    seed_v = $urandom(32'h5eed_0042);
    tx_den = 1; rx_den = 1; tx_trig = 6'd8; rx_trig = 6'd4;
    do_reset();
    // R1 reset state
    chk("R1 tx level", 32'(tx_level), 0);
    chk("R1 rx level", 32'(rx_level), 0);
    chk("R1 flags", {28'b0, tx_ovr, tx_udr, rx_ovr, rx_udr}, 0);
    chk("R1 rx dma", 32'(rx_dreq), 0);
    chk("R1 tx dma", 32'(tx_dreq), 1);
    chk("R1 tx irq", 32'(tx_irq), 1);

    // R2 R5: fill transmit with words, then one too many
    width = 2'b10;
    for (int i = 0; i < DEPTH / 4; i++) step(1, 32'h0403_0201 + 32'(i) * 32'h0404_0404, 0, 0, 0, 0);
    chk("R8 full no dma", 32'(tx_dreq), 0);
    step(1, 32'hdead_beef, 0, 0, 0, 0);
    chk("R5 tx overflow", 32'(tx_ovr), 1);
    repeat (3) step(0, 0, 0, 0, 0, 0);
    chk("R11 tx ovr held", 32'(tx_ovr), 1);
    // R3 drain in order, then one pop too many
    for (int i = 0; i < DEPTH; i++) step(0, 0, 0, 1, 0, 0);
    step(0, 0, 0, 1, 0, 0);
    chk("R6 tx underflow", 32'(tx_udr), 1);

    // R5 receive overflow with bytes
    width = 2'b00;
    for (int i = 0; i < DEPTH; i++) step(0, 0, 0, 0, 1, 8'(i * 3 + 1));
    step(0, 0, 0, 0, 1, 8'hee);
    chk("R5 rx overflow", 32'(rx_ovr), 1);
    // R4 reads at each width
    width = 2'b10; step(0, 0, 1, 0, 0, 0);
    width = 2'b01; step(0, 0, 1, 0, 0, 0);
    width = 2'b11; step(0, 0, 1, 0, 0, 0);
    width = 2'b00; step(0, 0, 1, 0, 0, 0);
    // R10 concurrent push and read
    while (rq.size() > 1) step(0, 0, 1, 0, 0, 0);
    step(0, 0, 1, 0, 1, 8'h5a);
    chk("R10 rx level", 32'(rx_level), 1);
    step(0, 0, 1, 0, 0, 0);
    // R6 read from empty
    width = 2'b01;
    step(0, 0, 1, 0, 0, 0);
    chk("R6 rx underflow", 32'(rx_udr), 1);

    do_reset();
    chk("R11 flags cleared by reset", {28'b0, tx_ovr, tx_udr, rx_ovr, rx_udr}, 0);

    // random traffic
    for (int i = 0; i < 6000; i++) begin
      if ($urandom_range(0, 15) == 0) begin
        width = 2'($urandom_range(0, 3));
        tx_trig = TRIG_W'($urandom_range(0, 63));
        rx_trig = TRIG_W'($urandom_range(0, 63));
        tx_den = 1'($urandom_range(0, 1));
        rx_den = 1'($urandom_range(0, 1));
        step(0, 0, 0, 0, 0, 0);
      end else begin
        step(1'($urandom_range(0, 2) == 0), $urandom(), 1'($urandom_range(0, 3) == 0),
             1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 8'($urandom()));
      end
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule